// File: doc/BRIEF.md
# Write-Through Data Cache Controller

This block places a small direct-mapped cache between the load/store stage of a CPU pipeline and a word-addressed memory. Each cache line holds exactly one memory word, and a memory word carries several CPU words side by side. Reads that hit are acknowledged combinationally in the cycle they are presented. The data follows one cycle later from an output register, so the pipeline can retire one load per clock. A read miss fetches the whole memory word, installs it, and then completes as a hit.

Every store is forwarded to memory. Only one request is in flight at a time. A store updates the cached copy only when its line is already present, and it never allocates a line. The CPU holds its request stable until it sees the acknowledge. A pipeline enable of `!cpu_req_i || cpu_got_o` is the intended way to drive the stage.

Top module: `wt_dcache`

## Requirements
- R1: The CPU address is the memory word address shifted left by log2(MEM_DATA_W/CPU_DATA_W), plus a low lane field. Lane k covers bits [k*CPU_DATA_W +: CPU_DATA_W] of the memory word, and `mem_addr_o` carries the CPU address shifted right by the lane field width.
- R2: A read whose line is valid with a matching tag raises `cpu_got_o` in the same cycle it is presented, and it raises no memory request.
- R3: After `cpu_got_o` for a read, `cpu_rdata_o` shows the addressed CPU word in the following cycle. It holds that word until the next read is acknowledged.
- R4: A read miss issues exactly one memory read (`mem_write_o`=0) of the line address. It waits for `mem_rstb_i`, installs `mem_rdata_i` and the tag, and acknowledges in a later cycle with the lane taken from the returned word.
- R5: Once `mem_req_o` is raised, it stays high with unchanged `mem_addr_o` and `mem_write_o` until a cycle in which `mem_rdy_i` is high.
- R6: Every write is issued to memory with `mem_write_o`=1. The CPU word is replicated into every lane of `mem_wdata_o`. `mem_wmask_o` carries `cpu_wmask_i` (bit i set enables byte i) in the addressed lane and zeros in the other lanes.
- R7: A write is acknowledged only in the cycle where its memory request meets `mem_rdy_i`. It is never acknowledged in the cycle it is first presented.
- R8: A write hit updates exactly the enabled bytes of the cached line. A later read of that word hits and returns the merged data.
- R9: A write miss fills no line, so a following read of the same address misses and fetches from memory.
- R10: While `rst_ni` is low, `cpu_got_o` and `mem_req_o` are low and every line is invalidated. The first read after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| cpu_req_i | input | 1 | CPU request valid |
| cpu_write_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | CPU_ADDR_W | CPU word address |
| cpu_wdata_i | input | CPU_DATA_W | Store data |
| cpu_wmask_i | input | CPU_DATA_W/8 | Store byte enables, 1 = write byte |
| cpu_got_o | output | 1 | Request acknowledge |
| cpu_rdata_o | output | CPU_DATA_W | Load data, one cycle after acknowledge |
| mem_req_o | output | 1 | Memory request valid |
| mem_write_o | output | 1 | Memory request is a write |
| mem_addr_o | output | MEM_ADDR_W | Memory word address |
| mem_wdata_o | output | MEM_DATA_W | Memory write data |
| mem_wmask_o | output | MEM_DATA_W/8 | Memory byte enables, 1 = write byte |
| mem_rdy_i | input | 1 | Memory accepts the request this cycle |
| mem_rstb_i | input | 1 | Read data valid strobe |
| mem_rdata_i | input | MEM_DATA_W | Memory read data |

## Verification
The bench uses the defaults: a 64-word memory of 64-bit words, 32-bit CPU words (two lanes per line) and eight lines. With three tags per index in the random address range, lines are evicted often, and both lanes and all byte-mask patterns appear in the mix. The memory model varies its ready latency from zero to several cycles and its read return from one to three cycles. This exposes acknowledge timing at both the shortest and the stretched handshakes.

// File: rtl/cwt_pkg.sv
package cwt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_WAIT = 2'd2,
    ST_WR_REQ  = 2'd3
  } cwt_state_e;
endpackage

// File: rtl/cwt_tag_store.sv
module cwt_tag_store #(
  parameter int LINES = 8,
  parameter int IDX_W = 3,
  parameter int TAG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [TAG_W-1:0] rd_tag_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (wr_en_i) begin
      for (int l = 0; l < LINES; l++) begin
        if (wr_idx_i == IDX_W'(l)) valid_q[l] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int l = 0; l < LINES; l++) begin
        if (wr_idx_i == IDX_W'(l)) tag_q[l] <= wr_tag_i;
      end
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
endmodule

// File: rtl/cwt_data_store.sv
module cwt_data_store #(
  parameter int LINES  = 8,
  parameter int IDX_W  = 3,
  parameter int LINE_W = 64,
  parameter int BYTES  = LINE_W / 8
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [LINE_W-1:0] rd_line_o,
  input  logic              fill_en_i,
  input  logic [LINE_W-1:0] fill_data_i,
  input  logic              upd_en_i,
  input  logic [BYTES-1:0]  upd_be_i,
  input  logic [LINE_W-1:0] upd_data_i
);
  logic [LINE_W-1:0] line_q [LINES];

  // fill and update never coincide: they come from different controller states
  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      line_q[idx_i] <= fill_data_i;
    end else if (upd_en_i) begin
      for (int b = 0; b < BYTES; b++) begin
        if (upd_be_i[b]) line_q[idx_i][b*8 +: 8] <= upd_data_i[b*8 +: 8];
      end
    end
  end

  assign rd_line_o = line_q[idx_i];
endmodule

// File: rtl/cwt_ctrl.sv
module cwt_ctrl
  import cwt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic write_i,
  input  logic hit_i,
  input  logic mem_rdy_i,
  input  logic mem_rstb_i,
  output logic got_o,
  output logic mem_req_o,
  output logic mem_write_o,
  output logic fill_o,
  output logic upd_o
);
  cwt_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d     = state_q;
    got_o       = 1'b0;
    mem_req_o   = 1'b0;
    mem_write_o = 1'b0;
    fill_o      = 1'b0;
    upd_o       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (write_i)    state_d = ST_WR_REQ;
          else if (hit_i) got_o   = 1'b1;
          else            state_d = ST_RD_REQ;
        end
      end
      ST_RD_REQ: begin
        mem_req_o = 1'b1;
        if (mem_rdy_i) state_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        // after the fill the held request returns through IDLE as a hit
        if (mem_rstb_i) begin
          fill_o  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WR_REQ: begin
        mem_req_o   = 1'b1;
        mem_write_o = 1'b1;
        if (mem_rdy_i) begin
          got_o   = 1'b1;
          upd_o   = hit_i;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int MEM_ADDR_W = 6,
  parameter int MEM_DATA_W = 64,
  parameter int CPU_DATA_W = 32,
  parameter int LINES      = 8,
  parameter int CPU_ADDR_W = MEM_ADDR_W + $clog2(MEM_DATA_W / CPU_DATA_W)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cpu_req_i,
  input  logic                    cpu_write_i,
  input  logic [CPU_ADDR_W-1:0]   cpu_addr_i,
  input  logic [CPU_DATA_W-1:0]   cpu_wdata_i,
  input  logic [CPU_DATA_W/8-1:0] cpu_wmask_i,
  output logic                    cpu_got_o,
  output logic [CPU_DATA_W-1:0]   cpu_rdata_o,
  output logic                    mem_req_o,
  output logic                    mem_write_o,
  output logic [MEM_ADDR_W-1:0]   mem_addr_o,
  output logic [MEM_DATA_W-1:0]   mem_wdata_o,
  output logic [MEM_DATA_W/8-1:0] mem_wmask_o,
  input  logic                    mem_rdy_i,
  input  logic                    mem_rstb_i,
  input  logic [MEM_DATA_W-1:0]   mem_rdata_i
);
  localparam int RATIO     = MEM_DATA_W / CPU_DATA_W;
  localparam int SEL_W     = $clog2(RATIO);
  localparam int LANE_W    = (SEL_W > 0) ? SEL_W : 1;
  localparam int CPU_BYTES = CPU_DATA_W / 8;
  localparam int MEM_BYTES = MEM_DATA_W / 8;
  localparam int IDX_W     = $clog2(LINES);
  localparam int TAG_W     = MEM_ADDR_W - IDX_W;

  logic [MEM_ADDR_W-1:0] line_addr;
  logic [LANE_W-1:0]     lane;
  logic [IDX_W-1:0]      idx;
  logic [TAG_W-1:0]      tag;
  logic                  tag_valid;
  logic [TAG_W-1:0]      tag_stored;
  logic                  hit;
  logic                  fill, upd, got;
  logic [MEM_DATA_W-1:0] line_data;
  logic [CPU_DATA_W-1:0] lane_data;
  logic [CPU_DATA_W-1:0] rdata_q;

  assign line_addr = MEM_ADDR_W'(cpu_addr_i >> SEL_W);
  assign lane      = LANE_W'(cpu_addr_i % RATIO);
  assign idx       = line_addr[IDX_W-1:0];
  assign tag       = line_addr[MEM_ADDR_W-1:IDX_W];
  assign hit       = tag_valid && (tag_stored == tag);

  cwt_tag_store #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (idx),
    .rd_valid_o (tag_valid),
    .rd_tag_o   (tag_stored),
    .wr_en_i    (fill),
    .wr_idx_i   (idx),
    .wr_tag_i   (tag)
  );

  cwt_data_store #(
    .LINES(LINES), .IDX_W(IDX_W), .LINE_W(MEM_DATA_W), .BYTES(MEM_BYTES)
  ) u_data (
    .clk_i       (clk_i),
    .idx_i       (idx),
    .rd_line_o   (line_data),
    .fill_en_i   (fill),
    .fill_data_i (mem_rdata_i),
    .upd_en_i    (upd),
    .upd_be_i    (mem_wmask_o),
    .upd_data_i  (mem_wdata_o)
  );

  cwt_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (cpu_req_i),
    .write_i     (cpu_write_i),
    .hit_i       (hit),
    .mem_rdy_i   (mem_rdy_i),
    .mem_rstb_i  (mem_rstb_i),
    .got_o       (got),
    .mem_req_o   (mem_req_o),
    .mem_write_o (mem_write_o),
    .fill_o      (fill),
    .upd_o       (upd)
  );

  // store data on every lane, enables only on the addressed one
  for (genvar l = 0; l < RATIO; l++) begin : g_lane
    assign mem_wdata_o[l*CPU_DATA_W +: CPU_DATA_W] = cpu_wdata_i;
    assign mem_wmask_o[l*CPU_BYTES +: CPU_BYTES]   =
      (lane == LANE_W'(l)) ? cpu_wmask_i : '0;
  end

  assign lane_data = line_data[lane*CPU_DATA_W +: CPU_DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rdata_q <= '0;
    else if (got && !cpu_write_i) rdata_q <= lane_data;
  end

  assign cpu_got_o   = got;
  assign cpu_rdata_o = rdata_q;
  assign mem_addr_o  = line_addr;
endmodule

// File: rtl/wt_dcache_chk.sv
module wt_dcache_chk #(
  parameter int MEM_ADDR_W = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  cpu_req_i,
  input logic                  cpu_write_i,
  input logic                  cpu_got_o,
  input logic                  mem_req_o,
  input logic                  mem_write_o,
  input logic [MEM_ADDR_W-1:0] mem_addr_o,
  input logic                  mem_rdy_i
);
  // R5
  mem_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rdy_i |=> mem_req_o);

  // R5
  mem_cmd_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rdy_i |=> $stable(mem_addr_o) && $stable(mem_write_o));

  // R7
  wr_got_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_got_o && cpu_write_i |-> mem_req_o && mem_write_o && mem_rdy_i);

  // R7
  wr_not_instant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_write_i && !mem_req_o |-> !cpu_got_o);

  // R2
  rd_got_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_got_o && !cpu_write_i |-> !mem_req_o);

  // R2
  got_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_got_o |-> cpu_req_i);
endmodule

bind wt_dcache wt_dcache_chk #(.MEM_ADDR_W(MEM_ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_write_i (cpu_write_i),
  .cpu_got_o   (cpu_got_o),
  .mem_req_o   (mem_req_o),
  .mem_write_o (mem_write_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rdy_i   (mem_rdy_i)
);

// File: tb/wt_dcache_bench.sv
`timescale 1ns/1ps
module wt_dcache_bench;
  localparam int MAW = 6, MDW = 64, CDW = 32, NL = 8;
  localparam int CAW = 7, NWORDS = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cpu_req = 1'b0, cpu_write = 1'b0;
  logic [CAW-1:0] cpu_addr = '0;
  logic [CDW-1:0] cpu_wdata = '0;
  logic [3:0] cpu_wmask = '0;
  logic cpu_got;
  logic [CDW-1:0] cpu_rdata;
  logic mem_req, mem_write;
  logic [MAW-1:0] mem_addr;
  logic [MDW-1:0] mem_wdata;
  logic [7:0] mem_wmask;
  logic mem_rdy = 1'b0, mem_rstb = 1'b0;
  logic [MDW-1:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  wt_dcache #(.MEM_ADDR_W(MAW), .MEM_DATA_W(MDW), .CPU_DATA_W(CDW), .LINES(NL)) u_wt_dcache (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_req_i(cpu_req), .cpu_write_i(cpu_write),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_wmask_i(cpu_wmask),
    .cpu_got_o(cpu_got), .cpu_rdata_o(cpu_rdata), .mem_req_o(mem_req),
    .mem_write_o(mem_write), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_wmask_o(mem_wmask), .mem_rdy_i(mem_rdy), .mem_rstb_i(mem_rstb),
    .mem_rdata_i(mem_rdata));

  int checks = 0, fails = 0;
  logic [MDW-1:0] mem_arr [NWORDS];
  logic [MDW-1:0] ref_mem [NWORDS];
  bit sh_valid [NL];
  int sh_tag [NL];
  int wait_cnt = 0, stall_fix = -1, rd_cnt = 0, rd_addr = 0;
  int rd_accepts = 0, last_rd_addr = -1;

  function automatic logic [MDW-1:0] init_word(int i);
    return {32'(i * 32'h01030507) ^ 32'hA5A5_0000, 32'(i * 7 + 3)};
  endfunction

  function automatic logic [MDW-1:0] merge(logic [MDW-1:0] old, int lane,
                                           logic [CDW-1:0] d, logic [3:0] m);
    logic [MDW-1:0] r = old;
    for (int b = 0; b < 4; b++)
      if (m[b]) r[lane*CDW + b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // memory model: decides ready and strobe at each falling edge
  always @(negedge clk) begin
    mem_rstb <= 1'b0;
    if (rd_cnt > 0) begin
      rd_cnt--;
      if (rd_cnt == 0) begin
        mem_rstb  <= 1'b1;
        mem_rdata <= mem_arr[rd_addr];
      end
    end
    mem_rdy <= 1'b0;
    if (rst_ni && mem_req) begin
      if (wait_cnt > 0) begin
        wait_cnt--;
      end else begin
        mem_rdy <= 1'b1;
        if (mem_write) begin
          for (int b = 0; b < 8; b++)
            if (mem_wmask[b]) mem_arr[mem_addr][b*8 +: 8] = mem_wdata[b*8 +: 8];
        end else begin
          rd_accepts++;
          last_rd_addr = int'(mem_addr);
          rd_addr = int'(mem_addr);
          rd_cnt = 1 + int'($urandom_range(0, 2));
        end
        wait_cnt = (stall_fix >= 0) ? stall_fix : int'($urandom_range(0, 2));
      end
    end
  end

  // one CPU access; called at a falling edge, returns at a falling edge
  task automatic access(input bit wr, input int addr, input logic [CDW-1:0] wd,
                        input logic [3:0] wm, input string rq, output int cyc);
    int line = addr / 2;
    int lane = addr % 2;
    int idx = line % NL;
    bit exp_hit = sh_valid[idx] && (sh_tag[idx] == line / NL);
    rd_accepts = 0;
    cpu_req = 1'b1; cpu_write = wr; cpu_addr = CAW'(addr);
    cpu_wdata = wd; cpu_wmask = wm;
    if (wr) ref_mem[line] = merge(ref_mem[line], lane, wd, wm);
    cyc = 0;
    #1;
    while (!cpu_got) begin
      @(negedge clk); #1; cyc++;
    end
    if (wr) begin
      // R7 no same-cycle write acknowledge
      check(cyc >= 1, "R7", 64'(cyc), 64'd1);
      // R6 memory word after store
      check(mem_arr[line] == ref_mem[line], "R6", mem_arr[line], ref_mem[line]);
    end else if (exp_hit) begin
      // R2 read hit same cycle, no memory read
      check(cyc == 0 && rd_accepts == 0, {rq, "/R2"}, 64'(cyc), 64'd0);
    end else begin
      // R4 one memory read of the line address (R1 address mapping)
      check(cyc >= 3 && rd_accepts == 1, {rq, "/R4"}, 64'(rd_accepts), 64'd1);
      check(last_rd_addr == line, "R1", 64'(last_rd_addr), 64'(line));
      sh_valid[idx] = 1'b1;
      sh_tag[idx] = line / NL;
    end
    @(negedge clk);
    cpu_req = 1'b0;
    if (!wr) // R3 data one cycle after acknowledge
      check(cpu_rdata == ref_mem[line][lane*CDW +: CDW], {rq, "/R3"},
            64'(cpu_rdata), 64'(ref_mem[line][lane*CDW +: CDW]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int c;
    void'($urandom(32'd12345));
    for (int i = 0; i < NWORDS; i++) begin
      mem_arr[i] = init_word(i);
      ref_mem[i] = init_word(i);
    end
    for (int i = 0; i < NL; i++) begin sh_valid[i] = 1'b0; sh_tag[i] = 0; end
    repeat (4) @(negedge clk);
    // R10 outputs quiet in reset
    check(!cpu_got && !mem_req, "R10", {cpu_got, mem_req}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 first read misses
    access(0, 5, '0, '0, "R10", c);
    // R2 back-to-back hits on both lanes
    access(0, 4, '0, '0, "R2", c);
    access(0, 5, '0, '0, "R2", c);
    access(0, 4, '0, '0, "R2", c);
    access(0, 5, '0, '0, "R2", c);
    // R8 write hit then merged read hit
    access(1, 5, 32'hDEAD_BEEF, 4'b0101, "R8", c);
    access(0, 5, '0, '0, "R8", c);
    check(c == 0, "R8", 64'(c), 0);
    // R9 write miss then read of same address misses
    access(1, 40, 32'h1234_5678, 4'b1111, "R9", c);
    access(0, 40, '0, '0, "R9", c);
    check(c >= 3, "R9", 64'(c), 64'd3);
    // R5 ready held low for several cycles
    stall_fix = 5; wait_cnt = 5;
    access(0, 30, '0, '0, "R5", c);
    check(c >= 8, "R5", 64'(c), 64'd8);
    wait_cnt = 5;
    access(1, 31, 32'hCAFE_F00D, 4'b1001, "R5", c);
    check(c >= 6, "R5", 64'(c), 64'd6);
    stall_fix = -1; wait_cnt = 0;
    access(0, 31, '0, '0, "R8", c);
    // random mix, three tags per index
    for (int n = 0; n < 400; n++) begin
      bit wr = ($urandom_range(0, 9) < 4);
      int a = int'($urandom_range(0, 47));
      access(wr, a, $urandom, 4'($urandom_range(0, 15)), "RND", c);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule